// File: doc/BRIEF.md
# Pseudorandom Bit-Error-Rate Tester with Slip Recovery

This block measures the bit error rate of a link or device under test. It sends a pseudorandom pattern on one or more lanes. It locks a local reference copy of that pattern onto the stream that comes back, then compares the returned stream with the reference, one bit per lane per clock. Mismatches go into a saturating error counter. The number of compared bits goes into a second counter, so the error rate is the ratio of the two.

A returned stream can gain or lose a whole word, for example when a receiver drops a sample or repeats one. Without special handling, the reference would then disagree with roughly half of all later bits, and one event would look like a huge error burst. The block watches for this case. The difference between two phases of a maximal-length sequence obeys the same feedback recurrence as the sequence itself. When the mismatch pattern on lane 0 keeps obeying that recurrence for a full register length, the block declares a slip. It then discards the mismatches still in flight, charges one error per lane, bumps a slip counter and reloads every reference from the incoming data. Each lane uses a different register length. Lane 0 has the longest one, and lane 0 alone decides when to lock and when a slip has happened.

Top module: `bert_prbs_tester`

## Requirements
- R1: Each transmit lane carries a maximal-length sequence that obeys x[t] = x[t-L] ^ x[t-T]. With the default parameters, lane 0 uses L=9, T=5 and lane 1 uses L=7, T=6.
- R2: Reset conditions:
  - While reset is asserted, and until the first start, `locked_o` is 0.
  - While reset is asserted, and until the first start, all three counters are 0.
- R3: A start pulse has these effects:
  - It clears all counters.
  - It enters the load phase.
  - `locked_o` goes to 1 exactly L0 clocks after the clock edge that samples start. L0 is the lane 0 length.
- R4: Once locked onto an error-free returned stream, the error and slip counters stay at zero.
- R5: Each received bit that differs from the reference adds exactly one to the error counter. This holds on any lane, and for simultaneous errors on several lanes. The count is visible no more than 2*L0+5 clocks later.
- R6: When the returned word stream drops a word or repeats a word, the following happens:
  - The slip counter increases by exactly 1.
  - The error counter increases by exactly LANES.
  - The block reloads and locks again.
- R7: Isolated bit errors that are more than L0 clocks apart are never reported as slips.
- R8: The bit counter increases by LANES on every clock in the measure phase. It stays unchanged on every other clock.
- R9: Every counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the counters and starts a new lock-and-measure run |
| tx_o | output | LANES | Pseudorandom bits sent to the device under test, one per lane |
| rx_i | input | LANES | Bits returned by the device under test, one per lane |
| locked_o | output | 1 | High while in the measure phase |
| err_cnt_o | output | CNT_W | Saturating count of bit errors |
| bit_cnt_o | output | CNT_W | Saturating count of compared bits |
| slip_cnt_o | output | SLIP_W | Saturating count of detected slips |

## Verification
The hardest situation to reach from the ports is a genuine slip, in which the error count must end up exactly LANES higher and must not include the many transient mismatches that came before detection. The bench produces this by holding the returned stream in a short word history and changing the tap it reads. Moving the tap one word closer drops a word. Moving it one word back repeats a word. The bench then waits for the block to relock and checks the exact totals. Isolated single errors on one lane and on both lanes at once are placed between the slips, so the totals also show that they are never mistaken for slips.

// File: rtl/bert_pkg.sv
package bert_pkg;

   localparam int NUM_POLY = 6;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_MEAS = 2'd2
   } bert_state_e;

   // Length of the maximal-length register selected by idx.
   function automatic int poly_len(input int idx);
      case (idx)
         0:       return 7;
         1:       return 9;
         2:       return 11;
         3:       return 15;
         4:       return 23;
         default: return 31;
      endcase
   endfunction

   // Second feedback tap paired with poly_len(idx).
   function automatic int poly_tap(input int idx);
      case (idx)
         0:       return 6;
         1:       return 5;
         2:       return 9;
         3:       return 14;
         4:       return 18;
         default: return 28;
      endcase
   endfunction

endpackage

// File: rtl/bert_prbs_gen.sv
module bert_prbs_gen #(
   parameter int LEN = 9,
   parameter int TAP = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic bit_o
);
   logic [LEN-1:0] sr_q;

   if (TAP >= LEN || TAP < 1) begin : g_bad_tap
      $error("bert_prbs_gen: TAP must lie in 1..LEN-1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '1;
      else         sr_q <= {sr_q[LEN-2:0], sr_q[LEN-1] ^ sr_q[TAP-1]};
   end

   assign bit_o = sr_q[0];
endmodule

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
   parameter int W     = 48,
   parameter int INC_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [W-1:0]     cnt_o
);
   localparam logic [W-1:0] MAX = '1;

   if (INC_W > W) begin : g_bad_w
      $error("bert_sat_cnt: increment wider than counter");
   end

   logic [W:0] sum;
   logic [W-1:0] cnt_q;

   assign sum = {1'b0, cnt_q} + (W+1)'(inc_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (sum[W])  cnt_q <= MAX;
      else              cnt_q <= sum[W-1:0];
   end

   assign cnt_o = cnt_q;

   // R9: a full counter stays full until cleared
   p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
endmodule

// File: rtl/bert_lane.sv
module bert_lane #(
   parameter int LEN     = 9,
   parameter int TAP     = 5,
   parameter int DLY     = 22,
   parameter bit SLIP_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic meas_i,
   input  logic flush_i,
   input  logic rx_i,
   output logic err_commit_o,
   output logic slip_o
);
   localparam int RUN_W = $clog2(LEN + 1);

   if (DLY < 2) begin : g_bad_dly
      $error("bert_lane: DLY must be at least 2");
   end

   logic [LEN-1:0] ref_q;
   logic           pred;
   logic           mis;
   logic           err_raw;
   logic [DLY-1:0] dly_q;

   assign pred    = ref_q[LEN-1] ^ ref_q[TAP-1];
   assign mis     = rx_i ^ pred;
   assign err_raw = meas_i & mis;

   // Reference: filled from the line while loading, free-running while measuring.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ref_q <= '0;
      else if (load_i) ref_q <= {ref_q[LEN-2:0], rx_i};
      else if (meas_i) ref_q <= {ref_q[LEN-2:0], pred};
   end

   // Errors are held back until a slip verdict can no longer cancel them.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dly_q <= '0;
      else if (flush_i) dly_q <= '0;
      else              dly_q <= {dly_q[DLY-2:0], err_raw};
   end

   assign err_commit_o = dly_q[DLY-1];

   if (SLIP_EN) begin : g_slip
      logic [LEN-1:0]   hist_q;
      logic [RUN_W-1:0] run_q;
      logic             rec_ok;
      logic             live;

      // The mismatch stream of a slipped lane obeys the generator recurrence.
      assign rec_ok = mis == (hist_q[LEN-1] ^ hist_q[TAP-1]);
      assign live   = |hist_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hist_q <= '0;
            run_q  <= '0;
         end else if (flush_i || !meas_i) begin
            hist_q <= '0;
            run_q  <= '0;
         end else begin
            hist_q <= {hist_q[LEN-2:0], mis};
            if (rec_ok && live)
               run_q <= (run_q == RUN_W'(LEN)) ? run_q : run_q + 1'b1;
            else
               run_q <= '0;
         end
      end

      assign slip_o = meas_i && (run_q == RUN_W'(LEN));

      // R7: the run never passes the register length
      p_run_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         run_q <= RUN_W'(LEN));
   end else begin : g_noslip
      assign slip_o = 1'b0;
   end
endmodule

// File: rtl/bert_prbs_tester.sv
module bert_prbs_tester
   import bert_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int FIRST_IDX = 0,
   parameter int CNT_W     = 48,
   parameter int SLIP_W    = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   output logic [LANES-1:0]  tx_o,
   input  logic [LANES-1:0]  rx_i,
   output logic              locked_o,
   output logic [CNT_W-1:0]  err_cnt_o,
   output logic [CNT_W-1:0]  bit_cnt_o,
   output logic [SLIP_W-1:0] slip_cnt_o
);
   localparam int L0    = poly_len(FIRST_IDX + LANES - 1);
   localparam int DLY   = 2 * L0 + 4;
   localparam int LC_W  = $clog2(L0 + 1);
   localparam int INC_W = $clog2(LANES + 1);

   if (LANES < 1 || FIRST_IDX < 0 || FIRST_IDX + LANES > NUM_POLY) begin : g_bad_cfg
      $error("bert_prbs_tester: LANES/FIRST_IDX select a missing polynomial");
   end
   if (CNT_W < INC_W || SLIP_W < 1) begin : g_bad_cnt
      $error("bert_prbs_tester: counter widths too small");
   end

   bert_state_e      state_q;
   logic [LC_W-1:0]  ld_cnt_q;
   logic             meas;
   logic             load;
   logic             slip_evt;
   logic             flush;
   logic [LANES-1:0] commit;
   logic [LANES-1:0] slip;
   logic [INC_W-1:0] err_inc;
   logic [INC_W-1:0] bit_inc;

   assign meas     = (state_q == ST_MEAS);
   assign load     = (state_q == ST_LOAD);
   assign slip_evt = meas && slip[0];
   assign flush    = start_i || slip_evt;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int PIDX = FIRST_IDX + LANES - 1 - i;

      bert_prbs_gen #(
         .LEN (poly_len(PIDX)),
         .TAP (poly_tap(PIDX))
      ) u_gen (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .bit_o  (tx_o[i])
      );

      bert_lane #(
         .LEN     (poly_len(PIDX)),
         .TAP     (poly_tap(PIDX)),
         .DLY     (DLY),
         .SLIP_EN (i == 0)
      ) u_lane (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .load_i       (load),
         .meas_i       (meas),
         .flush_i      (flush),
         .rx_i         (rx_i[i]),
         .err_commit_o (commit[i]),
         .slip_o       (slip[i])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         ld_cnt_q <= '0;
      end else if (start_i) begin
         state_q  <= ST_LOAD;
         ld_cnt_q <= '0;
      end else begin
         case (state_q)
            ST_LOAD: begin
               ld_cnt_q <= ld_cnt_q + 1'b1;
               if (ld_cnt_q == LC_W'(L0 - 1)) state_q <= ST_MEAS;
            end
            ST_MEAS: begin
               if (slip_evt) begin
                  state_q  <= ST_LOAD;
                  ld_cnt_q <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      err_inc = '0;
      if (slip_evt) begin
         err_inc = INC_W'(LANES);
      end else begin
         for (int i = 0; i < LANES; i++) err_inc = err_inc + INC_W'(commit[i]);
      end
   end

   assign bit_inc = meas ? INC_W'(LANES) : '0;

   bert_sat_cnt #(.W(CNT_W), .INC_W(INC_W)) u_err_cnt (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i),
      .inc_i (err_inc), .cnt_o (err_cnt_o)
   );

   bert_sat_cnt #(.W(CNT_W), .INC_W(INC_W)) u_bit_cnt (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i),
      .inc_i (bit_inc), .cnt_o (bit_cnt_o)
   );

   bert_sat_cnt #(.W(SLIP_W), .INC_W(1)) u_slip_cnt (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i),
      .inc_i (slip_evt), .cnt_o (slip_cnt_o)
   );

   assign locked_o = meas;

   // R3: start clears every counter and enters loading
   p_start_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (err_cnt_o == '0 && bit_cnt_o == '0 && slip_cnt_o == '0 && !locked_o));
   // R6: a slip on lane 0 sends the block back to loading
   p_slip_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slip_evt && !start_i) |=> (state_q == ST_LOAD && ld_cnt_q == '0));
   // R8: no compared bits counted outside measuring
   p_bits_only_meas_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!meas && !start_i) |=> $stable(bit_cnt_o));
   // R5: error count never falls except on start
   p_err_mono_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> err_cnt_o >= $past(err_cnt_o));
endmodule

// File: tb/bert_prbs_tester_tb.sv
module bert_prbs_tester_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 2;
   localparam int L0 = 9;
   localparam int NV = 8;
   // action: 0 idle, 1 inject mask, 2 drop a word, 3 repeat a word
   localparam int V_ACT  [NV] = '{0, 1, 1, 1, 2, 1, 3, 0};
   localparam int V_MASK [NV] = '{0, 1, 2, 3, 0, 1, 0, 0};
   localparam int V_ERR  [NV] = '{0, 1, 2, 4, 6, 7, 9, 9};
   localparam int V_SLIP [NV] = '{0, 0, 0, 0, 1, 1, 2, 2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [LANES-1:0] tx, tx_s, rx = '0;
   logic locked, locked_s;
   logic [47:0] err_cnt, bit_cnt;
   logic [15:0] slip_cnt, slip_s;
   logic [3:0] err_s, bit_s;

   logic [LANES-1:0] hist [4];
   logic [LANES-1:0] mask = '0;
   int dsel = 2;
   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bert_prbs_tester #(.LANES(LANES)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_o(tx), .rx_i(rx),
      .locked_o(locked), .err_cnt_o(err_cnt), .bit_cnt_o(bit_cnt), .slip_cnt_o(slip_cnt)
   );

   bert_prbs_tester #(.LANES(LANES), .CNT_W(4)) u_sat (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_o(tx_s), .rx_i(rx),
      .locked_o(locked_s), .err_cnt_o(err_s), .bit_cnt_o(bit_s), .slip_cnt_o(slip_s)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Waits for a falling edge, then drives the next returned word.
   task automatic tick();
      @(negedge clk);
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = tx;
      rx = hist[dsel] ^ mask;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [LANES-1:0] seq [48];
      longint b0;
      int bad0, bad1;
      for (int k = 0; k < 4; k++) hist[k] = '0;
      ticks(3);
      // R2: reset state
      chk("R2 locked", locked, 0);
      chk("R2 counters", err_cnt + bit_cnt + slip_cnt, 0);
      rst_n = 1'b1;
      // R1: recurrence of both transmit lanes
      for (int t = 0; t < 48; t++) begin tick(); seq[t] = tx; end
      bad0 = 0; bad1 = 0;
      for (int t = 9; t < 48; t++) if (seq[t][0] != (seq[t-9][0] ^ seq[t-5][0])) bad0++;
      for (int t = 7; t < 48; t++) if (seq[t][1] != (seq[t-7][1] ^ seq[t-6][1])) bad1++;
      chk("R1 lane0 recurrence", bad0, 0);
      chk("R1 lane1 recurrence", bad1, 0);
      chk("R2 idle counters", err_cnt + bit_cnt + slip_cnt, 0);
      // R3: start and lock timing
      start = 1'b1; tick(); start = 1'b0;
      chk("R3 cleared", err_cnt + bit_cnt + slip_cnt, 0);
      ticks(L0 - 1);
      chk("R3 not yet locked", locked, 0);
      tick();
      chk("R3 locked", locked, 1);
      // R8: bit counter rate
      b0 = bit_cnt;
      ticks(100);
      chk("R8 bits per cycle", bit_cnt - b0, LANES * 100);
      // Vector table: R4 clean, R5/R7 isolated errors, R6 slips
      for (int v = 0; v < NV; v++) begin
         case (V_ACT[v])
            1: begin mask = V_MASK[v][LANES-1:0]; tick(); mask = '0; end
            2: begin dsel = dsel - 1; tick(); end
            3: begin dsel = dsel + 1; tick(); end
            default: tick();
         endcase
         ticks(300);
         chk(V_ACT[v] >= 2 ? "R6 errors" : (V_ACT[v] == 1 ? "R5 errors" : "R4 errors"),
             err_cnt, V_ERR[v]);
         chk(V_ACT[v] >= 2 ? "R6 slips" : "R7 slips", slip_cnt, V_SLIP[v]);
         chk("R6 relocked", locked, 1);
      end
      // R5/R9: further spaced errors push the narrow instance into saturation
      for (int n = 0; n < 8; n++) begin
         mask = 1; tick(); mask = '0;
         ticks(40);
      end
      ticks(60);
      chk("R5 error total", err_cnt, 17);
      chk("R7 no slip", slip_cnt, 2);
      chk("R9 error saturates", err_s, 15);
      chk("R9 bits saturate", bit_s, 15);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule